// File: doc/BRIEF.md
# Serial Row-Programming Instruction Sequencer

This block sits on the host side of a two-wire serial programming link to a target that runs 24-bit instructions. It writes one full row of the target's code memory. It does not shift raw data. It builds each instruction the target must execute as a 24-bit opcode word. Each opcode goes out as a 28-bit frame: a 4-bit command nibble of zero, then the 24-bit opcode. Every bit is sent least significant first on the data line, and the host drives the serial clock.

A request carries a 24-bit start address. The engine then sends the whole row procedure on its own:

- The reset-exit preamble.
- The control-register setup.
- The load of the page and write pointer.
- Repeated groups of data loads and latch writes.
- The two-step programming trigger.
- A final reset of the program counter.

The instruction words to program arrive on a valid/ready stream, four at a time. Each group of four 24-bit words is packed into six 16-bit literal moves into the target's working registers W0 to W5. The engine then sends a read-pointer setup and eight latch-write opcodes.

Top module: `rowprog_seq`

## Requirements
- R1: While reset is held and after it is released with no start, busy, done, word_ready, pgc and pgd are all 0.
- R2: Each frame is 28 bits with the zero command nibble first and the opcode's bit 0 as the fifth bit. Bits are least significant first. pgd is sampled at the rising edge of pgc and never changes while pgc is high. pgc stays high for exactly CLK_DIV system clocks per bit.
- R3: A row starts with the opcodes 0x000000, 0x040200 and 0x000000, in that order.
- R4: Next come 0x24001A and then 0x883B0A, which set up the control register for full-row programming.
- R5: A literal move of value v into register r is encoded as 0x2 in bits 23:20, v in bits 19:4 and r in bits 3:0. After R4 the engine sends three opcodes in this order:
  - a move of {8'h00, address[23:16]} into register 0;
  - 0x880190;
  - a move of address[15:0] into register 7.
- R6: For each group of four words w0 to w3 (in order of acceptance), six moves go out in order, into registers 0 to 5:
  - register 0 gets w0[15:0];
  - register 1 gets {w1[23:16], w0[23:16]};
  - register 2 gets w1[15:0];
  - register 3 gets w2[15:0];
  - register 4 gets {w3[23:16], w2[23:16]};
  - register 5 gets w3[15:0].
- R7: After the six moves of a group the engine sends RDPTR_OP (default 0xEB0300). It then sends the eight latch-write opcodes. By default these are 0xBB0BB6, 0xBBDBB6, 0xBBEBB6, 0xBB1BB6, 0xBB0BB6, 0xBBDBB6, 0xBBEBB6, 0xBB1BB6. The group repeats GROUPS times.
- R8: word_ready is high only while the engine waits for a group. Exactly 4 words are accepted per group. A word offered while no row is running is not taken.
- R9: After the last group the engine sends TRIG_OP0 (default 0xA8E761), then TRIG_OP1 (default 0x000000), then 0x040200, then 0x000000.
- R10: done is a one-cycle pulse. It comes after the final frame has been shifted out, in a cycle where busy is already 0.
- R11: A start request while busy is ignored. The running row is unchanged, and no second row follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to program one row; taken only when idle |
| start_addr | input | 24 | Destination address of the row, captured on start |
| busy | output | 1 | A row is in progress |
| done | output | 1 | One-cycle pulse after the final frame |
| word_valid | input | 1 | An instruction word is offered |
| word_data | input | 24 | The offered instruction word |
| word_ready | output | 1 | The engine takes a word this cycle if word_valid is high |
| pgc | output | 1 | Serial programming clock |
| pgd | output | 1 | Serial programming data, LSB first |

## Verification
The hardest case to reach is the group boundary. There the engine has issued the last latch write of one group and is already waiting for the next four words while that frame is still being shifted. Words that arrive late must stall the stream between frames without changing bit timing or packing.

The bench runs one row with words offered back to back and one with words held off for several cycles at a time. Each decoded frame is compared in order against a scoreboard built from the requirements. A start request is also injected in the middle of a row, and extra words are offered after the row ends, to show that both are ignored at the ports.

// File: rtl/rowprog_pkg.sv
package rowprog_pkg;

  localparam int INSTR_W     = 24;
  localparam int LIT_W       = 16;
  localparam int CMD_W       = 4;
  localparam int FRAME_BITS  = CMD_W + INSTR_W;
  localparam int GROUP_WORDS = 4;
  localparam int GROUP_REGS  = 6;
  localparam int LATCH_OPS_N = 8;

  localparam logic [CMD_W-1:0]   SERIAL_CMD  = 4'b0000;
  localparam logic [INSTR_W-1:0] OP_NOP      = 24'h000000;
  localparam logic [INSTR_W-1:0] OP_GOTO_RST = 24'h040200;
  localparam logic [INSTR_W-1:0] OP_CTRL_LIT = 24'h24001A;
  localparam logic [INSTR_W-1:0] OP_CTRL_MOV = 24'h883B0A;
  localparam logic [INSTR_W-1:0] OP_PAGE_MOV = 24'h880190;

  typedef enum logic [3:0] {
    PH_IDLE, PH_EXIT, PH_CTRL, PH_PTR, PH_FETCH, PH_REGS,
    PH_RDPTR, PH_LATCH, PH_TRIG, PH_PCRST, PH_DRAIN
  } phase_t;

  typedef logic [GROUP_WORDS-1:0][INSTR_W-1:0] group_t;

  // literal move: opcode nibble, 16-bit literal, destination register
  function automatic logic [INSTR_W-1:0] mov_lit(input logic [LIT_W-1:0] lit,
                                                 input logic [3:0] rd);
    return {4'h2, lit, rd};
  endfunction

  // packed register image for one group of four words
  function automatic logic [LIT_W-1:0] pack_reg(input group_t g, input logic [2:0] sel);
    logic [LIT_W-1:0] r;
    case (sel)
      3'd0:    r = g[0][15:0];
      3'd1:    r = {g[1][23:16], g[0][23:16]};
      3'd2:    r = g[1][15:0];
      3'd3:    r = g[2][15:0];
      3'd4:    r = {g[3][23:16], g[2][23:16]};
      3'd5:    r = g[3][15:0];
      default: r = '0;
    endcase
    return r;
  endfunction

  // index of the last instruction of each phase
  function automatic logic [2:0] phase_last(input phase_t p);
    logic [2:0] n;
    case (p)
      PH_EXIT:  n = 3'd2;
      PH_CTRL:  n = 3'd1;
      PH_PTR:   n = 3'd2;
      PH_REGS:  n = 3'(GROUP_REGS - 1);
      PH_LATCH: n = 3'(LATCH_OPS_N - 1);
      PH_TRIG:  n = 3'd1;
      PH_PCRST: n = 3'd1;
      default:  n = 3'd0;
    endcase
    return n;
  endfunction

  function automatic logic phase_emits(input phase_t p);
    return (p != PH_IDLE) && (p != PH_FETCH) && (p != PH_DRAIN);
  endfunction

endpackage

// File: rtl/rowprog_shifter.sv
module rowprog_shifter
  import rowprog_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [INSTR_W-1:0] frame_in,
  output logic               idle,
  output logic               frame_done,
  output logic               pgc,
  output logic               pgd
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic                  active;
  logic [FRAME_BITS-1:0] sr;
  logic [BW-1:0]         bitn;
  logic [DW-1:0]         divn;
  logic                  clk_q;
  logic                  tick;
  logic                  fall;

  assign tick       = active && (divn == DW'(DIV - 1));
  assign fall       = tick && clk_q;
  assign frame_done = fall && (bitn == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sr     <= '0;
      bitn   <= '0;
      divn   <= '0;
      clk_q  <= 1'b0;
    end else if (!active) begin
      if (load) begin
        active <= 1'b1;
        sr     <= {frame_in, SERIAL_CMD};
        bitn   <= '0;
        divn   <= '0;
        clk_q  <= 1'b0;
      end
    end else if (tick) begin
      divn  <= '0;
      clk_q <= !clk_q;
      if (fall) begin
        if (frame_done) begin
          active <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
          sr   <= sr >> 1;
        end
      end
    end else begin
      divn <= divn + 1'b1;
    end
  end

  assign idle = !active;
  assign pgc  = clk_q;
  assign pgd  = active & sr[0];
endmodule

// File: rtl/rowprog_packer.sv
module rowprog_packer
  import rowprog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               word_valid,
  input  logic [INSTR_W-1:0] word_data,
  output logic               word_ready,
  output logic               grp_full,
  output group_t             grp
);
  localparam int CW = $clog2(GROUP_WORDS);

  logic [CW-1:0] cnt;
  logic          accept;

  assign word_ready = take;
  assign accept     = take && word_valid;
  assign grp_full   = accept && (cnt == CW'(GROUP_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      grp <= '0;
    end else if (accept) begin
      grp[cnt] <= word_data;
      cnt      <= grp_full ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rowprog_opgen.sv
module rowprog_opgen
  import rowprog_pkg::*;
#(
  parameter logic [INSTR_W-1:0] RDPTR_OP = 24'hEB0300,
  parameter logic [INSTR_W-1:0] TRIG_OP0 = 24'hA8E761,
  parameter logic [INSTR_W-1:0] TRIG_OP1 = 24'h000000,
  parameter logic [LATCH_OPS_N-1:0][INSTR_W-1:0] LATCH_OPS = '0
) (
  input  phase_t             phase,
  input  logic [2:0]         sub,
  input  logic [INSTR_W-1:0] addr,
  input  group_t             grp,
  output logic [INSTR_W-1:0] instr
);
  always_comb begin
    instr = OP_NOP;
    case (phase)
      PH_EXIT:  instr = (sub == 3'd1) ? OP_GOTO_RST : OP_NOP;
      PH_CTRL:  instr = (sub == 3'd0) ? OP_CTRL_LIT : OP_CTRL_MOV;
      PH_PTR: begin
        case (sub)
          3'd0:    instr = mov_lit({8'h00, addr[23:16]}, 4'd0);
          3'd1:    instr = OP_PAGE_MOV;
          default: instr = mov_lit(addr[15:0], 4'd7);
        endcase
      end
      PH_REGS:  instr = mov_lit(pack_reg(grp, sub), {1'b0, sub});
      PH_RDPTR: instr = RDPTR_OP;
      PH_LATCH: instr = LATCH_OPS[sub];
      PH_TRIG:  instr = (sub == 3'd0) ? TRIG_OP0 : TRIG_OP1;
      PH_PCRST: instr = (sub == 3'd0) ? OP_GOTO_RST : OP_NOP;
      default:  instr = OP_NOP;
    endcase
  end
endmodule

// File: rtl/rowprog_seq.sv
module rowprog_seq
  import rowprog_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int GROUPS  = 16,
  parameter logic [INSTR_W-1:0] RDPTR_OP = 24'hEB0300,
  parameter logic [INSTR_W-1:0] TRIG_OP0 = 24'hA8E761,
  parameter logic [INSTR_W-1:0] TRIG_OP1 = 24'h000000,
  parameter logic [LATCH_OPS_N-1:0][INSTR_W-1:0] LATCH_OPS = {
    24'hBB1BB6, 24'hBBEBB6, 24'hBBDBB6, 24'hBB0BB6,
    24'hBB1BB6, 24'hBBEBB6, 24'hBBDBB6, 24'hBB0BB6}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] start_addr,
  output logic               busy,
  output logic               done,
  input  logic               word_valid,
  input  logic [INSTR_W-1:0] word_data,
  output logic               word_ready,
  output logic               pgc,
  output logic               pgd
);
  localparam int GCW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  phase_t             phase;
  logic [2:0]         sub;
  logic [GCW-1:0]     grp_cnt;
  logic [INSTR_W-1:0] addr_q;
  logic               done_q;

  // named internal events
  logic               shift_idle;
  logic               frame_done;
  logic               frame_issue;
  logic               grp_full;
  logic               phase_end;
  logic               last_group;
  logic [INSTR_W-1:0] instr;
  group_t             grp;

  assign frame_issue = phase_emits(phase) && shift_idle;
  assign phase_end   = (sub == phase_last(phase));
  assign last_group  = (grp_cnt == GCW'(GROUPS - 1));

  rowprog_packer u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (phase == PH_FETCH),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_ready (word_ready),
    .grp_full   (grp_full),
    .grp        (grp)
  );

  rowprog_opgen #(
    .RDPTR_OP  (RDPTR_OP),
    .TRIG_OP0  (TRIG_OP0),
    .TRIG_OP1  (TRIG_OP1),
    .LATCH_OPS (LATCH_OPS)
  ) u_gen (
    .phase (phase),
    .sub   (sub),
    .addr  (addr_q),
    .grp   (grp),
    .instr (instr)
  );

  rowprog_shifter #(.DIV(CLK_DIV)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_issue),
    .frame_in   (instr),
    .idle       (shift_idle),
    .frame_done (frame_done),
    .pgc        (pgc),
    .pgd        (pgd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      sub     <= '0;
      grp_cnt <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_EXIT;
            addr_q  <= start_addr;
            sub     <= '0;
            grp_cnt <= '0;
          end
        end
        PH_FETCH: begin
          if (grp_full) begin
            phase <= PH_REGS;
            sub   <= '0;
          end
        end
        PH_DRAIN: begin
          if (frame_done) begin
            phase  <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        default: begin
          if (frame_issue) begin
            if (!phase_end) begin
              sub <= sub + 1'b1;
            end else begin
              sub <= '0;
              case (phase)
                PH_EXIT:  phase <= PH_CTRL;
                PH_CTRL:  phase <= PH_PTR;
                PH_PTR:   phase <= PH_FETCH;
                PH_REGS:  phase <= PH_RDPTR;
                PH_RDPTR: phase <= PH_LATCH;
                PH_LATCH: begin
                  phase   <= last_group ? PH_TRIG : PH_FETCH;
                  grp_cnt <= grp_cnt + 1'b1;
                end
                PH_TRIG:  phase <= PH_PCRST;
                default:  phase <= PH_DRAIN;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);
  assign done = done_q;
endmodule

// File: rtl/rowprog_chk.sv
module rowprog_chk (
  input logic clk,
  input logic rst_n,
  input logic pgc,
  input logic pgd,
  input logic busy,
  input logic done,
  input logic word_ready,
  input logic frame_done,
  input logic frame_issue
);
  // R2: data held while the serial clock is high
  a_r2_pgd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pgc |-> $stable(pgd));
  // R2: no serial clock activity while idle
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pgc);
  // R2: a new frame is only launched with the clock low
  a_r2_issue_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_issue |-> !pgc);
  // R8: words are only requested during a row
  a_r8_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> busy);
  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: done with busy already low
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10: done follows the end of a frame
  a_r10_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(frame_done));
endmodule

bind rowprog_seq rowprog_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pgc         (pgc),
  .pgd         (pgd),
  .busy        (busy),
  .done        (done),
  .word_ready  (word_ready),
  .frame_done  (frame_done),
  .frame_issue (frame_issue)
);

// File: tb/rowprog_seq_bench.sv
`timescale 1ns/1ps
module rowprog_seq_bench;
  localparam int DIV = 2;
  localparam int GRP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, done, word_ready, pgc, pgd;
  logic        word_valid = 1'b0;
  logic [23:0] word_data = '0;

  always #2.5 clk = ~clk;

  rowprog_seq #(.CLK_DIV(DIV), .GROUPS(GRP)) u_rowprog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .pgc(pgc), .pgd(pgd));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] src_q[$];
  bit          gapped = 0;
  int          gap_cnt = 0;
  int          accepted = 0;
  int          frames = 0;
  bit          pend = 0;
  bit          ready_idle_seen = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] bmov(input logic [15:0] v, input logic [3:0] r);
    return 24'h200000 | ({8'h00, v} << 4) | {20'h0, r};
  endfunction

  function automatic logic [23:0] latch_op(input int i);
    case (i % 4)
      0: return 24'hBB0BB6;
      1: return 24'hBBDBB6;
      2: return 24'hBBEBB6;
      default: return 24'hBB1BB6;
    endcase
  endfunction

  task automatic push(input logic [23:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // word feeder: an acceptance decided at one negedge is retired at the next
  always @(negedge clk) begin
    if (pend) begin
      void'(src_q.pop_front());
      accepted++;
    end
    gap_cnt = (gap_cnt + 1) % 5;
    word_valid = (src_q.size() > 0) && (!gapped || gap_cnt == 0);
    word_data  = (src_q.size() > 0) ? src_q[0] : 24'h0;
    pend = word_valid && word_ready;
    if (!busy && word_ready) ready_idle_seen = 1;
  end

  // serial monitor
  logic        pgc_prev = 0;
  logic        pgd_rise = 0;
  logic [27:0] fsr = '0;
  int          nbits = 0;
  int          hi_len = 0;
  bit          tbad = 0;
  always @(negedge clk) begin
    if (pgc && !pgc_prev) begin
      fsr = {pgd, fsr[27:1]};
      pgd_rise = pgd;
      hi_len = 1;
      nbits++;
      if (nbits == 28) begin
        nbits = 0;
        frames++;
        check(fsr[3:0] == 4'b0000, "R2", "command nibble", {28'h0, fsr[3:0]}, 32'h0);
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected frame", {8'h0, fsr[27:4]}, 32'h0);
        end else begin
          string t;
          logic [23:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(fsr[27:4] == e, t, "frame opcode", {8'h0, fsr[27:4]}, {8'h0, e});
        end
      end
    end else if (pgc && pgc_prev) begin
      hi_len++;
      if (pgd != pgd_rise) tbad = 1;
    end else if (!pgc && pgc_prev) begin
      if (hi_len != DIV) tbad = 1;
    end
    pgc_prev = pgc;
  end

  task automatic run_row(input logic [23:0] addr, input int pat, input bit gap,
                         input bit stray);
    logic [23:0] w[4];
    int f0, n;
    push(24'h000000, "R3"); push(24'h040200, "R3"); push(24'h000000, "R3");
    push(24'h24001A, "R4"); push(24'h883B0A, "R4");
    push(bmov({8'h00, addr[23:16]}, 4'd0), "R5");
    push(24'h880190, "R5");
    push(bmov(addr[15:0], 4'd7), "R5");
    for (int g = 0; g < GRP; g++) begin
      for (int i = 0; i < 4; i++) begin
        if (pat == 0) w[i] = {8'(8'h13 + 8'(g * 4 + i) * 8'h11), 16'hA5C3 ^ 16'(16'h0101 * (g * 4 + i))};
        else w[i] = ((g * 4 + i) % 2 == 0) ? 24'hFFFFFF : 24'h00FF00;
        src_q.push_back(w[i]);
      end
      push(bmov(w[0][15:0], 4'd0), "R6");
      push(bmov({w[1][23:16], w[0][23:16]}, 4'd1), "R6");
      push(bmov(w[1][15:0], 4'd2), "R6");
      push(bmov(w[2][15:0], 4'd3), "R6");
      push(bmov({w[3][23:16], w[2][23:16]}, 4'd4), "R6");
      push(bmov(w[3][15:0], 4'd5), "R6");
      push(24'hEB0300, "R7");
      for (int k = 0; k < 8; k++) push(latch_op(k), "R7");
    end
    push(24'hA8E761, "R9"); push(24'h000000, "R9");
    push(24'h040200, "R9"); push(24'h000000, "R9");
    gapped = gap;
    accepted = 0;
    @(negedge clk);
    start_addr = addr; start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R11", "busy after start", {31'h0, busy}, 32'h1);
    if (stray) begin
      repeat (300) @(negedge clk);
      start_addr = 24'h777777; start = 1;   // R11: request while busy
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R10", "done seen", {31'h0, done}, 32'h1);
    check(busy == 1'b0, "R10", "busy low with done", {31'h0, busy}, 32'h0);
    check(exp_q.size() == 0, "R10", "frames left at done", exp_q.size(), 32'h0);
    check(accepted == 4 * GRP, "R8", "words accepted", accepted, 4 * GRP);
    check(tbad == 0, "R2", "bit timing and hold", {31'h0, tbad}, 32'h0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done one cycle", {31'h0, done}, 32'h0);
    f0 = frames;
    // R8: words offered outside a row are not taken
    src_q.push_back(24'h123456); src_q.push_back(24'h654321);
    gapped = 0;
    repeat (60) @(negedge clk);
    check(src_q.size() == 2, "R8", "idle words untouched", src_q.size(), 32'h2);
    check(frames == f0, "R11", "no extra frames", frames, f0);
    check(busy == 1'b0, "R11", "no second row", {31'h0, busy}, 32'h0);
    src_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1", "busy in reset", {31'h0, busy}, 32'h0);
    check(done == 0, "R1", "done in reset", {31'h0, done}, 32'h0);
    check(word_ready == 0, "R1", "ready in reset", {31'h0, word_ready}, 32'h0);
    check({pgc, pgd} == 2'b00, "R1", "serial pins in reset", {30'h0, pgc, pgd}, 32'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check({busy, done, word_ready, pgc, pgd} == 5'b0, "R1", "idle after reset",
          {27'h0, busy, done, word_ready, pgc, pgd}, 32'h0);
    run_row(24'h012340, 0, 0, 1);
    run_row(24'hFF00FF, 1, 1, 0);
    check(ready_idle_seen == 0, "R8", "ready while idle", {31'h0, ready_idle_seen}, 32'h0);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule